// File: doc/BRIEF.md
# Instruction-Encoding Selector with Per-Encoding Trap Vectors

This per-hart unit holds a selection register that names which of several mutually conflicting instruction encodings is active. It decodes that register into one gating bit for each alternative decoder. Each gating bit is meant to be one extra input to the AND term that enables its decoder. Changing the selection does nothing except move that gate. Extension-enable and power-control vectors pass through the block unchanged, so no extension is switched on or off and no hardware is powered down.

The machine, supervisor and user trap-vector registers are banked, with one full set per encoding. CSR accesses to a vector go to the bank of the encoding that is selected now. The three active vector outputs always show that bank, so a change of selection swaps the visible vectors without copying any data.

A build-time policy sets what happens at trap boundaries:
- **keep**: the selection is left alone.
- **force-default**: the selection drops to encoding 0.
- **settable-default**: the selection takes a default register that belongs to the trap's target mode.

Under the two non-keep policies, the previous selection is saved on trap entry and put back on trap return.

Top module: `encsel_ctrl`

## Requirements
- R1: Decoder-enable bit i is high exactly when the selection equals i, so at most one bit is high in any cycle.
- R2: The extension-enable and power-control outputs always equal their inputs, whatever the selection is or how it changes.
- R3: The selection CSR (address 0) accepts writes at every privilege. The privilege codes are user 0, supervisor 1 and machine 3.
- R4: The vector CSRs (machine at address 1, supervisor at 2, user at 3) read and write only the bank of the current selection.
- R5: One cycle after the selection changes, the vector outputs show the new selection's bank, and the contents of every other bank are unchanged.
- R6: Under the force-default policy, a trap entry whose target is machine or supervisor mode sets the selection to 0 on the next cycle. A trap entry that targets user mode leaves it unchanged.
- R7: Under the settable-default policy, the machine default (address 4) is writable only at machine privilege. The supervisor default (address 5) is writable at supervisor or machine privilege. On trap entry, the selection takes the target mode's default.
- R8: Under the force-default and settable-default policies, trap entry saves the previous selection, and the trap-return strobe restores it.
- R9: Under the keep policy, neither trap entry nor trap return changes the selection.
- R10: After reset, the following are all 0: the selection, both default registers and every vector in every bank. Decoder enable 0 is the only enable high.
- R11: A write to the selection or to a default register with a value at or above the number of encodings is ignored. The selection reads back zero-extended to the CSR width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 3 | CSR address (0 selection, 1 to 3 vectors, 4 and 5 defaults) |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for csr_addr, combinational |
| priv | input | 2 | Current privilege of the access |
| trap_enter | input | 1 | Trap-entry strobe |
| trap_mode | input | 2 | Target privilege of the trap |
| trap_ret | input | 1 | Trap-return strobe |
| ext_en_in | input | EXT_W | Extension-enable state in |
| ext_en_out | output | EXT_W | Extension-enable state out, unchanged |
| pwr_ctl_in | input | PWR_W | Power-control state in |
| pwr_ctl_out | output | PWR_W | Power-control state out, unchanged |
| dec_en | output | NUM_ENC | One-hot decoder gating bits |
| mvec | output | XLEN | Active machine trap vector |
| svec | output | XLEN | Active supervisor trap vector |
| uvec | output | XLEN | Active user trap vector |

## Verification
The assertions assume that trap entry and trap return never arrive in the same cycle. The restore check relies on this. The keep-policy check also assumes that no selection write lands in the cycle of a trap strobe. The bench follows both rules: it pulses each strobe alone, with csr_we low. Three instances, one per policy, share the same stimulus, so that the policies can be compared step by step.

// File: rtl/enc_sel_pkg.sv
package enc_sel_pkg;
    typedef enum logic [1:0] {
        POL_KEEP     = 2'd0,
        POL_FORCE    = 2'd1,
        POL_SETTABLE = 2'd2
    } trap_pol_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [2:0] A_SEL  = 3'd0;
    localparam logic [2:0] A_MVEC = 3'd1;
    localparam logic [2:0] A_SVEC = 3'd2;
    localparam logic [2:0] A_UVEC = 3'd3;
    localparam logic [2:0] A_MDEF = 3'd4;
    localparam logic [2:0] A_SDEF = 3'd5;

    localparam logic [1:0] VK_M = 2'd0;
    localparam logic [1:0] VK_S = 2'd1;
    localparam logic [1:0] VK_U = 2'd2;
endpackage

// File: rtl/enc_onehot.sv
module enc_onehot #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  en
);
    for (genvar i = 0; i < N; i++) begin : g_en
        assign en[i] = (sel == SW'(i));
    end
endmodule

// File: rtl/vec_bank.sv
module vec_bank #(
    parameter int NUM_ENC = 4,
    parameter int XLEN    = 32,
    parameter int SW      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      wkind,
    input  logic [SW-1:0]   wsel,
    input  logic [XLEN-1:0] wdata,
    input  logic [SW-1:0]   rsel,
    output logic [XLEN-1:0] mvec,
    output logic [XLEN-1:0] svec,
    output logic [XLEN-1:0] uvec
);
    import enc_sel_pkg::*;

    typedef struct packed {
        logic [XLEN-1:0] m;
        logic [XLEN-1:0] s;
        logic [XLEN-1:0] u;
    } vec_set_t;

    vec_set_t bank_d [NUM_ENC];
    vec_set_t bank_q [NUM_ENC];
    vec_set_t rd_set;

    always_comb begin
        for (int i = 0; i < NUM_ENC; i++) begin
            bank_d[i] = bank_q[i];
            if (we && wsel == SW'(i)) begin
                case (wkind)
                    VK_M:    bank_d[i].m = wdata;
                    VK_S:    bank_d[i].s = wdata;
                    VK_U:    bank_d[i].u = wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENC; i++) begin
            if (!rst_n) bank_q[i] <= '0;
            else        bank_q[i] <= bank_d[i];
        end
    end

    always_comb begin
        rd_set = bank_q[0];
        for (int i = 0; i < NUM_ENC; i++) begin
            if (rsel == SW'(i)) rd_set = bank_q[i];
        end
    end

    assign mvec = rd_set.m;
    assign svec = rd_set.s;
    assign uvec = rd_set.u;

    for (genvar i = 0; i < NUM_ENC; i++) begin : g_chk
        AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && wsel == SW'(i)) |=> $stable(bank_q[i])); // R5
    end
endmodule

// File: rtl/encsel_ctrl.sv
module encsel_ctrl
    import enc_sel_pkg::*;
#(
    parameter int        NUM_ENC = 4,
    parameter int        XLEN    = 32,
    parameter int        EXT_W   = 8,
    parameter int        PWR_W   = 4,
    parameter trap_pol_e POLICY  = POL_FORCE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [2:0]         csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic [1:0]         priv,
    input  logic               trap_enter,
    input  logic [1:0]         trap_mode,
    input  logic               trap_ret,
    input  logic [EXT_W-1:0]   ext_en_in,
    output logic [EXT_W-1:0]   ext_en_out,
    input  logic [PWR_W-1:0]   pwr_ctl_in,
    output logic [PWR_W-1:0]   pwr_ctl_out,
    output logic [NUM_ENC-1:0] dec_en,
    output logic [XLEN-1:0]    mvec,
    output logic [XLEN-1:0]    svec,
    output logic [XLEN-1:0]    uvec
);
    localparam int SW = (NUM_ENC > 1) ? $clog2(NUM_ENC) : 1;

    typedef struct packed {
        logic [SW-1:0] sel;
        logic [SW-1:0] saved;
        logic [SW-1:0] mdef;
        logic [SW-1:0] sdef;
    } sel_state_t;

    sel_state_t s_d, s_q;
    logic       wval_ok;
    logic       trap_ms;
    logic       vec_we;
    logic [1:0] vec_kind;

    always_comb begin
        s_d      = s_q;
        wval_ok  = (csr_wdata < XLEN'(NUM_ENC));
        trap_ms  = trap_enter && (trap_mode == PRIV_M || trap_mode == PRIV_S);
        vec_we   = csr_we && (csr_addr == A_MVEC || csr_addr == A_SVEC || csr_addr == A_UVEC);
        vec_kind = 2'(csr_addr - A_MVEC);

        if (csr_we && wval_ok && csr_addr == A_MDEF && priv == PRIV_M)
            s_d.mdef = csr_wdata[SW-1:0];
        if (csr_we && wval_ok && csr_addr == A_SDEF && (priv == PRIV_M || priv == PRIV_S))
            s_d.sdef = csr_wdata[SW-1:0];

        if (POLICY != POL_KEEP && trap_ms) begin
            s_d.saved = s_q.sel;
            if (POLICY == POL_FORCE)        s_d.sel = '0;
            else if (trap_mode == PRIV_M)   s_d.sel = s_q.mdef;
            else                            s_d.sel = s_q.sdef;
        end else if (POLICY != POL_KEEP && trap_ret) begin
            s_d.sel = s_q.saved;
        end else if (csr_we && csr_addr == A_SEL && wval_ok) begin
            s_d.sel = csr_wdata[SW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    enc_onehot #(.N(NUM_ENC), .SW(SW)) u_onehot (
        .sel (s_q.sel),
        .en  (dec_en)
    );

    vec_bank #(.NUM_ENC(NUM_ENC), .XLEN(XLEN), .SW(SW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vec_we),
        .wkind (vec_kind),
        .wsel  (s_q.sel),
        .wdata (csr_wdata),
        .rsel  (s_q.sel),
        .mvec  (mvec),
        .svec  (svec),
        .uvec  (uvec)
    );

    always_comb begin
        case (csr_addr)
            A_SEL:   csr_rdata = XLEN'(s_q.sel);
            A_MVEC:  csr_rdata = mvec;
            A_SVEC:  csr_rdata = svec;
            A_UVEC:  csr_rdata = uvec;
            A_MDEF:  csr_rdata = XLEN'(s_q.mdef);
            A_SDEF:  csr_rdata = XLEN'(s_q.sdef);
            default: csr_rdata = '0;
        endcase
    end

    assign ext_en_out  = ext_en_in;
    assign pwr_ctl_out = pwr_ctl_in;

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec_en) == 1); // R1
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(s_q.sel) < NUM_ENC); // R11
    AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_FORCE && trap_ms) |=> dec_en[0]); // R6
    AST_KEEP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_KEEP && (trap_enter || trap_ret) && !(csr_we && csr_addr == A_SEL))
        |=> $stable(s_q.sel)); // R9
    AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY != POL_KEEP && trap_ret && !trap_enter) |=> s_q.sel == $past(s_q.saved)); // R8
endmodule

// File: tb/encsel_ctrl_test.sv
module encsel_ctrl_test;
    import enc_sel_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  priv = PRIV_M;
    logic        trap_enter = 1'b0;
    logic [1:0]  trap_mode = PRIV_M;
    logic        trap_ret = 1'b0;
    logic [7:0]  ext_in = '0;
    logic [3:0]  pwr_in = '0;

    logic [31:0] rd_f, rd_k, rd_s, mv_f, sv_f, uv_f, mv_k, sv_k, uv_k, mv_s, sv_s, uv_s;
    logic [7:0]  ext_f, ext_k, ext_s;
    logic [3:0]  pwr_f, pwr_k, pwr_s, en_f, en_k, en_s;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    encsel_ctrl #(.POLICY(POL_FORCE)) uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(rd_f), .priv(priv), .trap_enter(trap_enter), .trap_mode(trap_mode),
        .trap_ret(trap_ret), .ext_en_in(ext_in), .ext_en_out(ext_f), .pwr_ctl_in(pwr_in),
        .pwr_ctl_out(pwr_f), .dec_en(en_f), .mvec(mv_f), .svec(sv_f), .uvec(uv_f));

    encsel_ctrl #(.POLICY(POL_KEEP)) uut_keep (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(rd_k), .priv(priv), .trap_enter(trap_enter), .trap_mode(trap_mode),
        .trap_ret(trap_ret), .ext_en_in(ext_in), .ext_en_out(ext_k), .pwr_ctl_in(pwr_in),
        .pwr_ctl_out(pwr_k), .dec_en(en_k), .mvec(mv_k), .svec(sv_k), .uvec(uv_k));

    encsel_ctrl #(.POLICY(POL_SETTABLE)) uut_set (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(rd_s), .priv(priv), .trap_enter(trap_enter), .trap_mode(trap_mode),
        .trap_ret(trap_ret), .ext_en_in(ext_in), .ext_en_out(ext_s), .pwr_ctl_in(pwr_in),
        .pwr_ctl_out(pwr_s), .dec_en(en_s), .mvec(mv_s), .svec(sv_s), .uvec(uv_s));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write; state is visible at the following negedge.
    task automatic csr_wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] p);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d; priv = p;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd_at(input logic [2:0] a);
        csr_addr = a;
        #0.5;
    endtask

    task automatic trap_in(input logic [1:0] m);
        @(negedge clk);
        trap_enter = 1'b1; trap_mode = m;
        @(negedge clk);
        trap_enter = 1'b0;
    endtask

    task automatic trap_out();
        @(negedge clk);
        trap_ret = 1'b1;
        @(negedge clk);
        trap_ret = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 enables", 32'(en_f), 32'h1);
        rd_at(A_SEL);  chk("R10 sel", rd_f, 0);
        rd_at(A_MDEF); chk("R10 mdef", rd_s, 0);
        rd_at(A_SDEF); chk("R10 sdef", rd_s, 0);
        chk("R10 mvec", mv_f, 0);
        chk("R10 svec", sv_f, 0);
        chk("R10 uvec", uv_f, 0);
    endtask

    task automatic t_select();
        for (int i = 0; i < 4; i++) begin
            csr_wr(A_SEL, 32'(3 - i), PRIV_U);
            chk("R1 R3 onehot from user", 32'(en_f), 32'(1) << (3 - i));
        end
        csr_wr(A_SEL, 32'd2, PRIV_U);
        rd_at(A_SEL); chk("R11 zero-extended read", rd_f, 32'd2);
    endtask

    task automatic t_invalid();
        csr_wr(A_SEL, 32'd4, PRIV_M);
        chk("R11 value 4 ignored", 32'(en_f), 32'h4);
        csr_wr(A_SEL, 32'hFFFF_FFF3, PRIV_M);
        rd_at(A_SEL); chk("R11 wide value ignored", rd_f, 32'd2);
        csr_wr(A_MDEF, 32'd7, PRIV_M);
        rd_at(A_MDEF); chk("R11 default out of range ignored", rd_s, 32'd0);
    endtask

    task automatic t_banks();
        csr_wr(A_SEL, 32'd1, PRIV_U);
        csr_wr(A_MVEC, 32'hA1A1_0001, PRIV_M);
        csr_wr(A_SVEC, 32'hB1B1_0001, PRIV_M);
        csr_wr(A_UVEC, 32'hC1C1_0001, PRIV_M);
        csr_wr(A_SEL, 32'd3, PRIV_U);
        chk("R5 new bank mvec empty", mv_f, 0);
        chk("R5 new bank svec empty", sv_f, 0);
        csr_wr(A_MVEC, 32'hA3A3_0003, PRIV_M);
        rd_at(A_MVEC); chk("R4 read bank 3", rd_f, 32'hA3A3_0003);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = A_SEL; csr_wdata = 32'd1; priv = PRIV_U;
        #0.5;
        chk("R5 before edge still bank 3", mv_f, 32'hA3A3_0003);
        @(negedge clk);
        csr_we = 1'b0;
        chk("R5 bank 1 mvec intact", mv_f, 32'hA1A1_0001);
        chk("R5 bank 1 svec intact", sv_f, 32'hB1B1_0001);
        chk("R4 bank 1 uvec", uv_f, 32'hC1C1_0001);
        rd_at(A_SVEC); chk("R4 read bank 1 svec", rd_f, 32'hB1B1_0001);
        csr_wr(A_SEL, 32'd0, PRIV_U);
        chk("R4 bank 0 untouched", mv_f, 0);
    endtask

    task automatic t_passthru();
        ext_in = 8'h5A; pwr_in = 4'h9;
        for (int i = 0; i < 4; i++) begin
            csr_wr(A_SEL, 32'(i), PRIV_U);
            chk("R2 ext passes", 32'(ext_f), 32'h5A);
            chk("R2 pwr passes", 32'(pwr_f), 32'h9);
        end
        ext_in = 8'hC3; pwr_in = 4'h6;
        #0.5;
        chk("R2 ext follows input", 32'(ext_f), 32'hC3);
        chk("R2 pwr follows input", 32'(pwr_f), 32'h6);
    endtask

    task automatic t_defaults();
        csr_wr(A_MDEF, 32'd3, PRIV_U);
        rd_at(A_MDEF); chk("R7 mdef blocked from user", rd_s, 0);
        csr_wr(A_MDEF, 32'd3, PRIV_S);
        rd_at(A_MDEF); chk("R7 mdef blocked from super", rd_s, 0);
        csr_wr(A_MDEF, 32'd3, PRIV_M);
        rd_at(A_MDEF); chk("R7 mdef from machine", rd_s, 32'd3);
        csr_wr(A_SDEF, 32'd1, PRIV_U);
        rd_at(A_SDEF); chk("R7 sdef blocked from user", rd_s, 0);
        csr_wr(A_SDEF, 32'd1, PRIV_S);
        rd_at(A_SDEF); chk("R7 sdef from super", rd_s, 32'd1);
    endtask

    task automatic t_traps();
        csr_wr(A_SEL, 32'd2, PRIV_U);
        trap_in(PRIV_S);
        chk("R6 force to 0 on S trap", 32'(en_f), 32'h1);
        chk("R9 keep on S trap", 32'(en_k), 32'h4);
        chk("R7 settable takes sdef", 32'(en_s), 32'h2);
        trap_out();
        chk("R8 force restored", 32'(en_f), 32'h4);
        chk("R9 keep on return", 32'(en_k), 32'h4);
        chk("R8 settable restored", 32'(en_s), 32'h4);
        trap_in(PRIV_M);
        chk("R6 force to 0 on M trap", 32'(en_f), 32'h1);
        chk("R6 bank 0 vectors active", mv_f, 0);
        chk("R7 settable takes mdef", 32'(en_s), 32'h8);
        chk("R9 keep on M trap", 32'(en_k), 32'h4);
        trap_out();
        chk("R8 force restored after M", 32'(en_f), 32'h4);
        chk("R8 settable restored after M", 32'(en_s), 32'h4);
        trap_in(PRIV_U);
        chk("R6 user-target trap no change", 32'(en_f), 32'h4);
        chk("R7 user-target trap no change", 32'(en_s), 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_invalid();
        t_banks();
        t_passthru();
        t_defaults();
        t_traps();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule